// File: doc/BRIEF.md
# Wave Sample Memory Arbiter

This block holds the sample memory of a wave playback channel. The memory is 16 bytes, and each byte holds two 4-bit samples, so it stores 32 samples. A CPU reads and writes the memory one byte at a time. The playback engine reads one nibble at its current sample position.

The engine drives three signals: a playing flag, a 5-bit sample position and an access-window strobe. The arbiter uses these signals and a model-select input to decide three things for each CPU access:
- which byte the access reaches;
- whether a write is accepted;
- what a read returns.

While the channel is idle, the CPU address picks the byte. While it plays, every CPU access goes to the byte the engine is on, whatever the address. On the early model, during playback, an access outside the engine's access window is blocked.

The memory has no reset value. Software loads it before playback starts.

Top module: `wave_ram_arbiter`

## Requirements
- R1: While `play` is low, `cpu_rdata` shows the byte chosen by `cpu_addr`, in the same cycle, on either model.
- R2: While `play` is low, a clocked write with `cpu_wr` high stores `cpu_wdata` in the byte chosen by `cpu_addr`.
- R3: While `play` is high and `early_model` is low, `cpu_rdata` shows byte `pos >> 1`, whatever `cpu_addr` holds.
- R4: While `play` is high and `early_model` is low, a write always lands in byte `pos >> 1` and is never blocked.
- R5: With `early_model`, `play` and `win` all high, reads and writes are redirected to byte `pos >> 1`, as in R3 and R4.
- R6: With `early_model` and `play` high and `win` low, `cpu_rdata` is 0xFF, in reset as well.
- R7: With `early_model` and `play` high and `win` low, a write changes no byte.
- R8: `eng_nibble` is bits 7:4 of byte `pos >> 1` when `pos` bit 0 is 0, and bits 3:0 of that byte when `pos` bit 0 is 1.
- R9: A write in a cycle at whose closing edge `pos` advances lands in the byte of the position held before that edge.
- R10: While `rst_n` is low, no write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; blocks writes |
| cpu_addr | input | 4 | CPU byte address within the memory |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| play | input | 1 | Channel is playing |
| pos | input | 5 | Current sample position |
| win | input | 1 | Engine access window is open |
| early_model | input | 1 | Selects the early-model blocking behaviour |
| eng_nibble | output | 4 | Sample at the current position |

## Verification
The bench uses the default parameters: 16 bytes of 8 bits, which gives a 4-bit address and a 5-bit position. With these values, one sweep of `pos` reaches every byte and both nibble halves of each byte. Because the model-select line is a port, the bench covers both the redirect-only behaviour and the window-blocked behaviour in a single build. It also covers the cases where a write coincides with a position step or falls inside reset.

// File: rtl/wave_ram_arbiter.sv
module wave_ram_arbiter #(
  parameter int BYTES = 16,
  parameter int DW = 8,
  localparam int AW = $clog2(BYTES),
  localparam int PW = AW + 1,
  localparam int NW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          play,
  input  logic [PW-1:0] pos,
  input  logic          win,
  input  logic          early_model,
  output logic [NW-1:0] eng_nibble
);
  logic [DW-1:0] mem [BYTES];

  wire [AW-1:0] cur     = pos[PW-1:1];
  wire [AW-1:0] sel     = play ? cur : cpu_addr;
  wire          blocked = early_model & play & ~win;

  always_ff @(posedge clk)
    if (rst_n && cpu_wr && !blocked) mem[sel] <= cpu_wdata;

  assign cpu_rdata = blocked ? {DW{1'b1}} : mem[sel];

  wire [DW-1:0] cur_byte = mem[cur];
  assign eng_nibble = pos[0] ? cur_byte[NW-1:0] : cur_byte[DW-1:NW];
endmodule

// File: rtl/wave_ram_arbiter_chk.sv
module wave_ram_arbiter_chk #(
  parameter int BYTES = 16,
  parameter int DW = 8,
  localparam int AW = $clog2(BYTES),
  localparam int PW = AW + 1,
  localparam int NW = DW / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          play,
  input logic [PW-1:0] pos,
  input logic          win,
  input logic          early_model,
  input logic [NW-1:0] eng_nibble
);
  a_r2_idle_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (!play && cpu_wr) |=>
      (play || cpu_addr != $past(cpu_addr) || cpu_rdata == $past(cpu_wdata)));

  a_r4_play_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (play && cpu_wr && (!early_model || win)) |=>
      (!play || pos[PW-1:1] != $past(pos[PW-1:1]) || (early_model && !win)
       || cpu_rdata == $past(cpu_wdata)));

  a_r6_blocked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (early_model && play && !win) |-> cpu_rdata == {DW{1'b1}});

  a_r7_blocked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (early_model && play && !win && cpu_wr) |=>
      (pos != $past(pos) || eng_nibble == $past(eng_nibble)));

  a_r8_nibble_half: assert property (@(posedge clk) disable iff (!rst_n)
    (play && (!early_model || win)) |->
      (eng_nibble == (pos[0] ? cpu_rdata[NW-1:0] : cpu_rdata[DW-1:NW])));
endmodule

bind wave_ram_arbiter wave_ram_arbiter_chk #(.BYTES(BYTES), .DW(DW)) u_chk (.*);

// File: tb/wave_ram_arbiter_test.sv
module wave_ram_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cpu_wr = 0, play = 0, win = 0, early_model = 0;
  logic [3:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [4:0] pos = 0;
  wire  [7:0] cpu_rdata;
  wire  [3:0] eng_nibble;

  logic [7:0] model [16];
  bit valid [16];
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_ram_arbiter uut (.*);

  task automatic cyc(bit rn, bit wr, int a, int d, bit pl, int p, bit w, bit e, string tag);
    int idx;
    bit blk;
    logic [7:0] exp_rd;
    logic [3:0] exp_nib;
    @(negedge clk);
    rst_n = rn; cpu_wr = wr; cpu_addr = a[3:0]; cpu_wdata = d[7:0];
    play = pl; pos = p[4:0]; win = w; early_model = e;
    #(CLK_PERIOD/4);
    idx = pl ? (p >> 1) : a;
    blk = e && pl && !w;
    if (blk || valid[idx]) begin
      exp_rd = blk ? 8'hFF : model[idx];
      checks++;
      if (cpu_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", tag, cpu_rdata, exp_rd);
      end
    end
    if (valid[p >> 1]) begin
      exp_nib = p[0] ? model[p >> 1][3:0] : model[p >> 1][7:4];
      checks++;
      if (eng_nibble !== exp_nib) begin
        errors++;
        $display("FAIL R8 (%s) nibble actual=%h expected=%h", tag, eng_nibble, exp_nib);
      end
    end
    @(posedge clk);
    if (wr && rn && !blk) begin
      model[idx] = d[7:0];
      valid[idx] = 1;
    end
  endtask

  initial begin
    // reset state: blocked read returns all ones (R6)
    cyc(0, 0, 0, 0, 1, 3, 0, 1, "R6");
    cyc(0, 0, 5, 0, 1, 20, 0, 1, "R6");
    // R2: load memory while idle
    for (int i = 0; i < 16; i++) cyc(1, 1, i, (i * 8'h11) ^ 8'h5A, 0, 0, 0, 0, "R2");
    // R1: idle readback on both models
    for (int i = 0; i < 16; i++) cyc(1, 0, i, 0, 0, 31 - i, 0, i % 2, "R1");
    // R3 and R8: sweep position with unrelated address
    for (int p = 0; p < 32; p++) cyc(1, 0, (p * 7) % 16, 0, 1, p, 0, 0, "R3");
    // R4: playing write ignores address
    cyc(1, 1, 3, 8'hC3, 1, 20, 0, 0, "R4");
    cyc(1, 0, 10, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 3, 0, 0, 0, 0, 0, "R4");
    // R5: early model inside window
    cyc(1, 1, 0, 8'h7E, 1, 4, 1, 1, "R5");
    cyc(1, 0, 9, 0, 1, 5, 1, 1, "R5");
    cyc(1, 0, 2, 0, 0, 0, 0, 0, "R5");
    // R6 and R7: early model outside window
    cyc(1, 0, 1, 0, 1, 12, 0, 1, "R6");
    cyc(1, 1, 6, 8'h99, 1, 12, 0, 1, "R7");
    cyc(1, 0, 6, 0, 0, 12, 0, 0, "R7");
    cyc(1, 0, 6, 0, 1, 13, 1, 1, "R7");
    // R9: write while position steps across a byte boundary
    cyc(1, 1, 0, 8'h42, 1, 15, 0, 0, "R9");
    cyc(1, 0, 0, 0, 1, 16, 0, 0, "R9");
    cyc(1, 0, 7, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 8, 0, 0, 0, 0, 0, "R9");
    // R10: writes ignored while in reset
    cyc(0, 1, 2, 8'hEE, 0, 0, 0, 0, "R10");
    cyc(1, 0, 2, 0, 0, 0, 0, 0, "R10");
    cyc(0, 1, 5, 8'h11, 1, 10, 0, 0, "R10");
    cyc(1, 0, 5, 0, 0, 0, 0, 0, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule